// File: doc/BRIEF.md
# Four-Source Interrupt Latch and Vector Controller

This block collects the interrupt requests of a small 8-bit core and turns them into one request with a vector address. There are four sources. Source 1 is a timer request that is active low. Source 2 is an edge event taken from a vertical-sync pin. Source 3 is a second active-low timer request. Source 4 is an active-low power request. The power request comes from a latch that a selected edge of the power-input pin sets, and software can reset that latch.

Edge events are held in flags. Clearing the global enable does not clear those flags. A held flag is presented as soon as the global enable is set again.

The winning request leaves the block as a valid/ready stream with one 12-bit vector per transfer. While `irq_valid` is high and `irq_ready` is low (back-pressure), the held vector and `irq_valid` do not change. A transfer happens on a rising clock edge where both are high. That transfer is the service acknowledge for the source whose vector was presented. In the next cycle `irq_valid` is low, and the sources are evaluated again. The timers, the core pipeline and the stack are outside this block.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After an asynchronous reset (`rst_n` low), `irq_valid` is 0, and it stays 0 while no source is pending.
- R2: Source 1 is pending while `t2_req_n`=0, `t2_mask`=1 and option bit 6 (`opt_reg[6]`, level-source enable) is 1. Its vector is 0xFF6.
- R3: Source 3 is pending while `t1_req_n`=0 and `t1_mask`=1. Its vector is 0xFF2.
- R4: The internal sync signal is the inverse of `vsync_pin`. When `opt_reg[5]`=1, a rising edge of that internal signal (the pin falling) is recorded. When `opt_reg[5]`=0, a falling edge of that signal (the pin rising) is recorded. An edge is recorded only if `vsync_en` is 1 at the clock edge that samples it. A recorded edge makes source 2 pending, with vector 0xFF4.
- R5: Once the sync flag is set, it clears only when a transfer presents vector 0xFF4. Clearing the global enable does not clear it, and neither does clearing `vsync_en`.
- R6: The power latch is set by the chosen `pwr_pin` edge when `pwr_en`=1. `pwr_rise_sel`=1 selects the rising edge and 0 selects the falling edge. The latch is cleared only by `pwr_latch_clr`. Source 4 is pending while `pwr_en`=1 and the latch is set, with vector 0xFF0. A transfer does not clear the latch.
- R7: No request is presented while the global enable `opt_reg[4]` is 0. Edge flags captured during that time are presented once `opt_reg[4]` returns to 1.
- R8: When several sources are pending, the lowest-numbered one wins. Source n has the vector 0xFF8 - 2·n.
- R9: While `irq_valid`=1 and `irq_ready`=0, `irq_valid` stays 1 and `irq_vector` stays unchanged, even if a source of higher priority becomes pending.
- R10: After a transfer, `irq_valid` is 0 for one cycle. In the following cycle the pending sources are evaluated again.
- R11: A level request pending before a clock edge is presented after that edge. An edge event is presented one clock edge after the edge that records it.
- R12: If an edge is recorded in the same cycle as its flag's clear (a transfer for the sync flag, `pwr_latch_clr` for the power latch), the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opt_reg | input | 3 | Option bits [6:4]: 6 = level-source enable, 5 = sync edge select, 4 = global enable |
| t2_req_n | input | 1 | Timer 2 request, active low |
| t2_mask | input | 1 | Timer 2 mask, 1 forwards the request |
| t1_req_n | input | 1 | Timer 1 request, active low |
| t1_mask | input | 1 | Timer 1 mask, 1 forwards the request |
| vsync_pin | input | 1 | Vertical-sync pin level |
| vsync_en | input | 1 | Individual enable of the sync source |
| pwr_pin | input | 1 | Power-input pin level |
| pwr_en | input | 1 | Individual enable of the power source |
| pwr_rise_sel | input | 1 | Power latch edge: 1 = rising, 0 = falling |
| pwr_latch_clr | input | 1 | Software reset of the power latch |
| irq_valid | output | 1 | Request presented |
| irq_ready | input | 1 | Core accepts the request (service acknowledge) |
| irq_vector | output | 12 | Vector address of the presented source |

## Verification
The bench builds the block with its default parameters: four sources, a 12-bit vector and a top vector of 0xFF8. At this size every input pattern that matters can be swept directly. The sweeps cover all 64 settings of the two timer requests, their masks, the level-source enable and the global enable. They cover every combination of sync edge select, sync enable and pin direction, and the same for the power latch. They also cover all 16 subsets of pending sources, where the bench computes the expected vector as 0xFF8 - 2·n. Because the set is this small, the bench can also reach the exact cycles of the corner cases: an edge that coincides with its clear, back-pressure while a source of higher priority arrives, and a flag captured under global disable.

// File: rtl/irq_lc_pkg.sv
package irq_lc_pkg;
  localparam int NUM_SRC  = 4;
  localparam int IDX_W    = $clog2(NUM_SRC);
  localparam int VEC_W    = 12;
  localparam logic [VEC_W-1:0] VEC_TOP = 12'hFF8;
  localparam int VEC_STEP = 2;

  // option field positions (decoded by the core's register map)
  localparam int OPT_GLOB_BIT = 4;
  localparam int OPT_SYNC_BIT = 5;
  localparam int OPT_LVL_BIT  = 6;

  typedef enum logic [IDX_W-1:0] {
    SRC_TMR2 = 2'd0,
    SRC_SYNC = 2'd1,
    SRC_TMR1 = 2'd2,
    SRC_PWR  = 2'd3
  } src_e;

  // source index i is interrupt number i+1
  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    return VEC_TOP - VEC_W'(VEC_STEP) * (VEC_W'(idx) + VEC_W'(1));
  endfunction
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic en_i,
  input  logic rise_sel_i,
  input  logic clr_i,
  output logic flag_o
);
  logic primed_q;
  logic pin_q;
  logic flag_q;
  logic hit;

  // no edge is seen until one sample has been taken after reset
  assign hit = primed_q & en_i &
               (rise_sel_i ? (~pin_q & pin_i) : (pin_q & ~pin_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      pin_q    <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      primed_q <= 1'b1;
      pin_q    <= pin_i;
      if (hit)        flag_q <= 1'b1;   // a new event outranks a clear
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] grant;

  for (genvar g = 0; g < N; g++) begin : g_grant
    if (g == 0) begin : g_first
      assign grant[g] = req_i[g];
    end else begin : g_rest
      assign grant[g] = req_i[g] & ~(|req_i[g-1:0]);
    end
  end

  assign any_o = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/irq_present.sv
module irq_present #(
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any_i,
  input  logic [IW-1:0] idx_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o,
  output logic          fire_o
);
  logic          vld_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      idx_q <= '0;
    end else if (vld_q) begin
      if (ready_i) vld_q <= 1'b0;   // one idle cycle before re-evaluation
    end else if (any_i) begin
      vld_q <= 1'b1;
      idx_q <= idx_i;
    end
  end

  assign valid_o = vld_q;
  assign idx_o   = idx_q;
  assign fire_o  = vld_q & ready_i;
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_lc_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [OPT_LVL_BIT:OPT_GLOB_BIT] opt_reg,
  input  logic                            t2_req_n,
  input  logic                            t2_mask,
  input  logic                            t1_req_n,
  input  logic                            t1_mask,
  input  logic                            vsync_pin,
  input  logic                            vsync_en,
  input  logic                            pwr_pin,
  input  logic                            pwr_en,
  input  logic                            pwr_rise_sel,
  input  logic                            pwr_latch_clr,
  output logic                            irq_valid,
  input  logic                            irq_ready,
  output logic [VEC_W-1:0]                irq_vector
);
  logic               sync_flag;
  logic               pwr_latch;
  logic               sync_int;
  logic               fire;
  logic [IDX_W-1:0]   held_idx;
  logic [IDX_W-1:0]   win_idx;
  logic               win_any;
  logic [NUM_SRC-1:0] src_raw;
  logic [NUM_SRC-1:0] src_live;

  // internal sync signal is the pin inverted; edge select acts on it
  assign sync_int = ~vsync_pin;

  irq_edge_latch u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (sync_int),
    .en_i       (vsync_en),
    .rise_sel_i (opt_reg[OPT_SYNC_BIT]),
    .clr_i      (fire && (held_idx == SRC_SYNC)),
    .flag_o     (sync_flag)
  );

  irq_edge_latch u_pwr (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (pwr_pin),
    .en_i       (pwr_en),
    .rise_sel_i (pwr_rise_sel),
    .clr_i      (pwr_latch_clr),
    .flag_o     (pwr_latch)
  );

  assign src_raw[SRC_TMR2] = ~t2_req_n & t2_mask & opt_reg[OPT_LVL_BIT];
  assign src_raw[SRC_SYNC] = sync_flag;
  assign src_raw[SRC_TMR1] = ~t1_req_n & t1_mask;
  assign src_raw[SRC_PWR]  = pwr_en & pwr_latch;   // power line reads inactive when disabled

  assign src_live = src_raw & {NUM_SRC{opt_reg[OPT_GLOB_BIT]}};

  irq_prio_pick #(.N(NUM_SRC), .IW(IDX_W)) u_pick (
    .req_i (src_live),
    .any_o (win_any),
    .idx_o (win_idx)
  );

  irq_present #(.IW(IDX_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .any_i   (win_any),
    .idx_i   (win_idx),
    .ready_i (irq_ready),
    .valid_o (irq_valid),
    .idx_o   (held_idx),
    .fire_o  (fire)
  );

  assign irq_vector = vec_of(held_idx);
endmodule

// File: rtl/irq_latch_ctrl_chk.sv
module irq_latch_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [6:4]  opt_reg,
  input logic        t2_req_n,
  input logic        t2_mask,
  input logic        pwr_latch_clr,
  input logic        irq_valid,
  input logic        irq_ready,
  input logic [11:0] irq_vector,
  input logic        sync_flag,
  input logic        pwr_latch
);
  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_ready |=> irq_valid && $stable(irq_vector));

  // R8
  legal_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector == 12'hFF6 || irq_vector == 12'hFF4 ||
                   irq_vector == 12'hFF2 || irq_vector == 12'hFF0));

  // R10
  idle_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_ready |=> !irq_valid);

  // R7
  glob_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> $past(opt_reg[4]));

  // R8
  first_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) && $past(!t2_req_n && t2_mask && opt_reg[6]) |-> irq_vector == 12'hFF6);

  // R5
  sync_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_flag) |-> $past(irq_valid && irq_ready && irq_vector == 12'hFF4));

  // R6
  pwr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_latch) |-> $past(pwr_latch_clr));
endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .opt_reg       (opt_reg),
  .t2_req_n      (t2_req_n),
  .t2_mask       (t2_mask),
  .pwr_latch_clr (pwr_latch_clr),
  .irq_valid     (irq_valid),
  .irq_ready     (irq_ready),
  .irq_vector    (irq_vector),
  .sync_flag     (sync_flag),
  .pwr_latch     (pwr_latch)
);

// File: tb/irq_latch_ctrl_tb.sv
module irq_latch_ctrl_tb_top;
  localparam int CLK_PERIOD   = 10;
  localparam int WATCHDOG_CYC = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic glob = 1'b0, sync_sel = 1'b0, lvl = 1'b0;
  logic t2_req_n = 1'b1, t2_mask = 1'b0, t1_req_n = 1'b1, t1_mask = 1'b0;
  logic vsync_pin = 1'b1, vsync_en = 1'b0;
  logic pwr_pin = 1'b0, pwr_en = 1'b0, pwr_rise_sel = 1'b0, pwr_latch_clr = 1'b0;
  logic irq_ready = 1'b0;
  logic irq_valid;
  logic [11:0] irq_vector;
  logic [6:4] opt_reg;

  int n_cmp = 0;
  int n_bad = 0;

  assign opt_reg = {lvl, sync_sel, glob};

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_latch_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .opt_reg(opt_reg),
    .t2_req_n(t2_req_n), .t2_mask(t2_mask), .t1_req_n(t1_req_n), .t1_mask(t1_mask),
    .vsync_pin(vsync_pin), .vsync_en(vsync_en),
    .pwr_pin(pwr_pin), .pwr_en(pwr_en), .pwr_rise_sel(pwr_rise_sel),
    .pwr_latch_clr(pwr_latch_clr),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_vector(irq_vector)
  );

  function automatic logic [11:0] vec_exp(input int n);
    return 12'hFF8 - 12'(2 * n);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // n = 0 means no request expected
  task automatic check_out(input string tag, input int n);
    check(tag, 32'(irq_valid), 32'(n != 0));
    if (n != 0) check(tag, 32'(irq_vector), 32'(vec_exp(n)));
  endtask

  task automatic drain();
    t2_req_n = 1'b1; t1_req_n = 1'b1; t2_mask = 1'b0; t1_mask = 1'b0;
    glob = 1'b1; pwr_latch_clr = 1'b1; irq_ready = 1'b1;
    tick(8);
    pwr_latch_clr = 1'b0; irq_ready = 1'b0;
    tick(2);
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    check("R1 valid during reset", 32'(irq_valid), 0);
    rst_n = 1'b1;
    tick(3);
    check_out("R1 idle after reset", 0);

    // R2 R3 R7 R11: level sweep, presented one edge later
    for (int c = 0; c < 64; c++) begin
      logic p1, p3, ev;
      glob = c[0]; lvl = c[1]; t2_req_n = c[2]; t2_mask = c[3];
      t1_req_n = c[4]; t1_mask = c[5];
      p1 = !c[2] && c[3] && c[1];
      p3 = !c[4] && c[5];
      ev = c[0] && (p1 || p3);
      tick(1);
      check_out("R2/R3/R7/R11 level sweep", ev ? (p1 ? 1 : 3) : 0);
      drain();
    end

    // R4 R11: sync edge sweep
    for (int s = 0; s < 2; s++) begin
      for (int e = 0; e < 2; e++) begin
        for (int a = 0; a < 2; a++) begin
          logic hit;
          glob = 1'b1; sync_sel = s[0]; vsync_en = 1'b0; vsync_pin = a[0];
          tick(2);
          vsync_en = e[0];
          vsync_pin = ~a[0];
          hit = e[0] && (s[0] ? (a[0] == 1'b1) : (a[0] == 1'b0));
          tick(1);
          check_out("R11 sync not yet presented", 0);
          tick(1);
          check_out("R4 sync edge sweep", hit ? 2 : 0);
          drain();
          check_out("R5 sync cleared by service", 0);
        end
      end
    end

    // R7 R5: captured under global disable, survives enable clear
    glob = 1'b0; sync_sel = 1'b1; vsync_en = 1'b0; vsync_pin = 1'b1;
    tick(2);
    vsync_en = 1'b1; vsync_pin = 1'b0;
    tick(4);
    check_out("R7 no request while globally off", 0);
    vsync_en = 1'b0;
    tick(2);
    check_out("R7 still off", 0);
    glob = 1'b1;
    tick(1);
    check_out("R7 flag presented on re-enable", 2);
    irq_ready = 1'b1;
    tick(1);
    irq_ready = 1'b0;
    check_out("R10 idle after transfer", 0);
    tick(2);
    check_out("R5 flag gone after service", 0);

    // R4: individually disabled before the edge
    vsync_en = 1'b0; vsync_pin = 1'b1;
    tick(2);
    vsync_pin = 1'b0;
    tick(2);
    vsync_en = 1'b1;
    tick(3);
    check_out("R4 edge ignored when disabled", 0);
    drain();

    // R6: power latch sweep
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 2; a++) begin
        logic hit;
        glob = 1'b1; pwr_rise_sel = s[0]; pwr_en = 1'b0; pwr_pin = a[0];
        tick(2);
        pwr_en = 1'b1;
        pwr_pin = ~a[0];
        hit = s[0] ? (a[0] == 1'b0) : (a[0] == 1'b1);
        tick(2);
        check_out("R6 power edge sweep", hit ? 4 : 0);
        if (hit) begin
          irq_ready = 1'b1;
          tick(1);
          irq_ready = 1'b0;
          check_out("R10 idle after power transfer", 0);
          tick(1);
          check_out("R6 latch kept across transfer", 4);
          pwr_en = 1'b0;
          irq_ready = 1'b1;
          tick(1);
          irq_ready = 1'b0;
          tick(2);
          check_out("R6 disabled power reads inactive", 0);
          pwr_en = 1'b1;
          tick(2);
          check_out("R6 latch kept while disabled", 4);
        end
        drain();
        check_out("R6 latch cleared by software", 0);
        pwr_en = 1'b0;
      end
    end

    // R12: power edge together with software clear
    glob = 1'b1; pwr_rise_sel = 1'b1; pwr_en = 1'b1; pwr_pin = 1'b0;
    tick(2);
    pwr_pin = 1'b1; pwr_latch_clr = 1'b1;
    tick(1);
    pwr_latch_clr = 1'b0;
    tick(1);
    check_out("R12 power edge beats clear", 4);
    drain();
    pwr_en = 1'b0;

    // R12: sync edge together with its service transfer
    sync_sel = 1'b1; vsync_en = 1'b0; vsync_pin = 1'b1;
    tick(2);
    vsync_en = 1'b1; vsync_pin = 1'b0;
    tick(2);
    check_out("R4 sync presented", 2);
    vsync_pin = 1'b1;
    tick(1);
    irq_ready = 1'b1; vsync_pin = 1'b0;
    tick(1);
    irq_ready = 1'b0;
    check_out("R10 idle after sync transfer", 0);
    tick(1);
    check_out("R12 sync edge beats service", 2);
    drain();
    vsync_en = 1'b0;

    // R9 R8: back-pressure while higher priority arrives
    glob = 1'b1; t1_req_n = 1'b0; t1_mask = 1'b1;
    tick(1);
    check_out("R3 timer1 presented", 3);
    lvl = 1'b1; t2_req_n = 1'b0; t2_mask = 1'b1;
    tick(3);
    check_out("R9 held under back-pressure", 3);
    irq_ready = 1'b1;
    tick(1);
    irq_ready = 1'b0;
    check_out("R10 idle after transfer", 0);
    tick(1);
    check_out("R8 re-evaluation picks source 1", 1);
    drain();

    // R8: all 16 subsets of pending sources
    for (int m = 0; m < 16; m++) begin
      int win;
      glob = 1'b0; sync_sel = 1'b1; lvl = 1'b1; pwr_rise_sel = 1'b1;
      if (m[1]) begin
        vsync_en = 1'b0; vsync_pin = 1'b1; tick(2);
        vsync_en = 1'b1; vsync_pin = 1'b0; tick(1);
      end
      if (m[3]) begin
        pwr_en = 1'b0; pwr_pin = 1'b0; tick(2);
        pwr_en = 1'b1; pwr_pin = 1'b1; tick(1);
      end else begin
        pwr_en = 1'b0;
      end
      t2_req_n = ~m[0]; t2_mask = m[0];
      t1_req_n = ~m[2]; t1_mask = m[2];
      win = 0;
      for (int b = 3; b >= 0; b--) if (m[b]) win = b + 1;
      glob = 1'b1;
      tick(1);
      check_out("R8 priority sweep", win);
      drain();
      vsync_en = 1'b0; pwr_en = 1'b0;
      check_out("R8 priority sweep drained", 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule